// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a blocking data cache that sits between a processor and a slow main memory with a wide data bus. The processor issues one word access at a time. An access can be a read or a write, and it uses a byte address. The processor holds its valid strobe until the cache answers with a one-cycle ready pulse. Each cache line holds four 32-bit words. Placement is direct-mapped: the line index comes from low address bits, and the remaining upper bits are kept as the tag.

A four-state controller runs every access. After a request is accepted, it is compared against the stored tag. A hit finishes at once. A miss first writes the old line back to memory if that line holds modified data. The controller then fetches the new line and repeats the compare, which now hits.

Writes are write-back with write-allocate. A write that hits changes only the cache and marks the line modified. Each memory transaction is one full line and takes several cycles. The memory strobe stays asserted until the memory answers with ready.

Top module: `dmc_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. Both the processor ready and the memory valid outputs are low.
- R2: The address is split into three fields. The byte offset is the low 4 bits, and bits 3..2 of it pick the word within the line. The line index is the next IDX_W bits, and all remaining upper bits form the tag.
- R3: A read hit returns the addressed word with ready high in the first cycle after the request is accepted. Ready is a single-cycle pulse.
- R4: A write hit changes only the cached word and marks the line modified. It starts no memory transaction.
- R5: A miss on a line that is unmodified, or invalid, issues exactly one memory read. The read address is the request address with the 4 offset bits cleared. Ready comes after the fill and the repeated compare, LAT+2 cycles after acceptance when the memory answers after LAT cycles.
- R6: A miss on a valid modified line first writes the whole old line to memory, with the data exactly as it was. The write address is formed from the stored tag and the index, with a zero offset. The memory read for the new line starts only after that write completes.
- R7: A write miss fetches the line, merges the new word into it and marks it modified. A later replacement of that line therefore writes it back.
- R8: Memory valid, memory write and memory address stay constant while memory ready is low. Memory write is high only during a write-back.
- R9: The request is captured when it is accepted. Changes to the processor address or write data during a miss do not alter the result.
- R10: Address bits 1..0 are ignored: any byte address inside a word reaches that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor request strobe, held until ready |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Processor byte address |
| cpuWdata | input | 32 | Processor write word |
| cpuRdata | output | 32 | Read word, valid with cpuReady |
| cpuReady | output | 1 | One-cycle completion pulse |
| memValid | output | 1 | Memory transaction request |
| memWrite | output | 1 | 1 = line write-back, 0 = line fetch |
| memAddr | output | 32 | Line-aligned memory address |
| memWdata | output | 128 | Line being written back |
| memRdata | input | 128 | Line returned by memory |
| memReady | input | 1 | Memory transaction done |

## Verification
The bench builds the cache with IDX_W = 2, which gives four lines. Any two addresses that differ in bit 6 or above, and have the same bits 5..4, then fight over one line. Dirty evictions, clean refills and write-allocate evictions can all be reached with a handful of addresses and a 1 KB address range. The memory model answers after three cycles, so hit, clean-miss and dirty-miss latencies come out as 1, 5 and 9 cycles and can be told apart exactly.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_COMPARE   = 2'd1,
    ST_WRITEBACK = 2'd2,
    ST_ALLOCATE  = 2'd3
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch processor request
    logic lookup;   // tag compare cycle
    logic evict;    // write-back of victim line in flight
    logic alloc;    // line fetch in flight
    logic fill;     // fetched line arrives this cycle
  } dpStrobe_t;

endpackage

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuValid,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       memReady,
  output dpStrobe_t  strobe,
  output logic       cpuReady,
  output logic       memValid,
  output logic       memWrite
);

  ctrlState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:      if (cpuValid) stateD = ST_COMPARE;
      ST_COMPARE: begin
        if (hit)              stateD = ST_IDLE;
        else if (victimDirty) stateD = ST_WRITEBACK;
        else                  stateD = ST_ALLOCATE;
      end
      ST_WRITEBACK: if (memReady) stateD = ST_ALLOCATE;
      ST_ALLOCATE:  if (memReady) stateD = ST_COMPARE;
      default:      stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.capture = (stateQ == ST_IDLE) && cpuValid;
    strobe.lookup  = (stateQ == ST_COMPARE);
    strobe.evict   = (stateQ == ST_WRITEBACK);
    strobe.alloc   = (stateQ == ST_ALLOCATE);
    strobe.fill    = (stateQ == ST_ALLOCATE) && memReady;
  end

  assign cpuReady = (stateQ == ST_COMPARE) && hit;
  assign memValid = (stateQ == ST_WRITEBACK) || (stateQ == ST_ALLOCATE);
  assign memWrite = (stateQ == ST_WRITEBACK);

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid);

  // R3
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  // R6
  wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrite && memReady |=> memValid && !memWrite);

endmodule

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int IDX_W      = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    strobe,
  input  logic                         cpuWrite,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [WORD_W-1:0]            cpuWdata,
  output logic [WORD_W-1:0]            cpuRdata,
  output logic                         hit,
  output logic                         victimDirty,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [LINE_WORDS*WORD_W-1:0] memWdata,
  input  logic [LINE_WORDS*WORD_W-1:0] memRdata
);

  localparam int LINES  = 1 << IDX_W;
  localparam int LINE_W = LINE_WORDS * WORD_W;
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic [ADDR_W-1:0] reqAddr;
  logic              reqWrite;
  logic [WORD_W-1:0] reqWdata;

  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [LINE_W-1:0] dataQ [LINES];
  logic [LINES-1:0]  validQ;
  logic [LINES-1:0]  dirtyQ;

  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [WSEL_W-1:0] reqWsel;
  logic [LINE_W-1:0] curLine;
  logic              mergeEn;

  assign reqIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqWsel = reqAddr[BYTE_W +: WSEL_W];
  assign curLine = dataQ[reqIdx];

  assign hit         = validQ[reqIdx] && (tagQ[reqIdx] == reqTag);
  assign victimDirty = validQ[reqIdx] && dirtyQ[reqIdx];
  assign mergeEn     = strobe.lookup && hit && reqWrite;

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWrite <= 1'b0;
      reqWdata <= '0;
    end else if (strobe.capture) begin
      reqAddr  <= cpuAddr;
      reqWrite <= cpuWrite;
      reqWdata <= cpuWdata;
    end
  end

  // per-line status bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (strobe.fill) begin
      validQ[reqIdx] <= 1'b1;
      dirtyQ[reqIdx] <= 1'b0;
    end else if (mergeEn) begin
      dirtyQ[reqIdx] <= 1'b1;
    end
  end

  // tag and data storage
  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tagQ[reqIdx]  <= reqTag;
      dataQ[reqIdx] <= memRdata;
    end else if (mergeEn) begin
      dataQ[reqIdx][reqWsel*WORD_W +: WORD_W] <= reqWdata;
    end
  end

  assign cpuRdata = curLine[reqWsel*WORD_W +: WORD_W];
  assign memWdata = curLine;

  always_comb begin
    if (strobe.evict) memAddr = {tagQ[reqIdx], reqIdx, {OFF_W{1'b0}}};
    else              memAddr = {reqTag, reqIdx, {OFF_W{1'b0}}};
  end

  // R4
  dirty_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lookup && hit && reqWrite |=> dirtyQ[$past(reqIdx)]);

  // R5
  fill_hits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> hit);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(reqAddr) && $stable(reqWdata));

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int IDX_W      = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuValid,
  input  logic                         cpuWrite,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [WORD_W-1:0]            cpuWdata,
  output logic [WORD_W-1:0]            cpuRdata,
  output logic                         cpuReady,
  output logic                         memValid,
  output logic                         memWrite,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [LINE_WORDS*WORD_W-1:0] memWdata,
  input  logic [LINE_WORDS*WORD_W-1:0] memRdata,
  input  logic                         memReady
);

  dpStrobe_t strobe;
  logic      hit;
  logic      victimDirty;

  dmc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuValid   (cpuValid),
    .hit        (hit),
    .victimDirty(victimDirty),
    .memReady   (memReady),
    .strobe     (strobe),
    .cpuReady   (cpuReady),
    .memValid   (memValid),
    .memWrite   (memWrite)
  );

  dmc_datapath #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .LINE_WORDS(LINE_WORDS),
    .IDX_W     (IDX_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cpuWrite   (cpuWrite),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .cpuRdata   (cpuRdata),
    .hit        (hit),
    .victimDirty(victimDirty),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata)
  );

  // R8
  mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> $stable(memAddr) && $stable(memWrite));

endmodule

// File: tb/dmc_cache_bench.sv
module dmc_cache_bench;

  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuValid = 1'b0;
  logic         cpuWrite = 1'b0;
  logic [31:0]  cpuAddr = '0;
  logic [31:0]  cpuWdata = '0;
  logic [31:0]  cpuRdata;
  logic         cpuReady;
  logic         memValid;
  logic         memWrite;
  logic [31:0]  memAddr;
  logic [127:0] memWdata;
  logic [127:0] memRdata = '0;
  logic         memReady = 1'b0;

  always #2.5 clk = ~clk;

  dmc_cache #(.IDX_W(2)) u_dmc_cache (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] patWord(input int a);
    return 32'hC0DE_0000 ^ (a * 32'h9E37);
  endfunction

  // main memory and reference word image (1 KB)
  logic [127:0] mainMem [64];
  logic [31:0]  refMem  [256];
  int wrCnt = 0, rdCnt = 0, wrStamp = 0, rdStamp = 0, memCnt = 0;
  logic [31:0]  lastWrAddr = '0;
  logic [127:0] lastWrData = '0;

  // bench model of cache state
  logic [25:0] mTag [4];
  bit          mValid [4];
  bit          mDirty [4];

  typedef struct packed { logic isRead; logic [31:0] data; logic [31:0] addr; } expItem_t;
  expItem_t expQ [$];

  // memory model: answers LAT cycles after request
  initial begin
    forever begin
      @(negedge clk);
      if (memReady) begin
        memReady = 1'b0;
        memCnt = 0;
      end else if (memValid && rstN) begin
        memCnt++;
        if (memCnt == LAT) begin
          if (memWrite) begin
            mainMem[memAddr[9:4]] = memWdata;
            wrCnt++; wrStamp = cyc; lastWrAddr = memAddr; lastWrData = memWdata;
          end else begin
            memRdata = mainMem[memAddr[9:4]];
            rdCnt++; rdStamp = cyc;
          end
          memReady = 1'b1;
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && cpuReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R3 unexpected ready", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          if (it.isRead)
            chk(cpuRdata == it.data, "R3 R9 R10 read data", cpuRdata, it.data);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic lineOf(input int li, output logic [127:0] l);
    l = {refMem[4*li+3], refMem[4*li+2], refMem[4*li+1], refMem[4*li]};
  endtask

  task automatic doAccess(input bit wr, input logic [31:0] addr, input logic [31:0] wd);
    logic [1:0]   idx;
    logic [25:0]  tag;
    int           kind;  // 0 hit, 1 clean miss, 2 dirty miss
    int           expLat, waits, wr0, rd0;
    logic [31:0]  vAddr;
    logic [127:0] vLine;
    expItem_t     it;
    idx = addr[5:4];
    tag = addr[31:6];
    if (mValid[idx] && mTag[idx] == tag) kind = 0;
    else if (mValid[idx] && mDirty[idx]) kind = 2;
    else kind = 1;
    expLat = (kind == 0) ? 1 : (kind == 1) ? LAT + 2 : 2 * LAT + 3;
    vAddr = {mTag[idx], idx, 4'b0};
    lineOf(int'(vAddr[9:4]), vLine);
    mDirty[idx] = ((kind == 0) ? mDirty[idx] : 1'b0) | wr;
    mValid[idx] = 1'b1;
    mTag[idx]   = tag;
    if (wr) refMem[addr[9:2]] = wd;
    it.isRead = !wr; it.data = refMem[addr[9:2]]; it.addr = addr;
    expQ.push_back(it);
    wr0 = wrCnt; rd0 = rdCnt;
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = addr; cpuWdata = wd;
    waits = 0;
    forever begin
      @(negedge clk);
      waits++;
      if (cpuReady) break;
      // R9: scramble processor inputs while the miss is in progress
      cpuAddr = ~addr; cpuWdata = ~wd;
      if (waits > 60) break;
    end
    cpuValid = 1'b0;
    if (kind == 0) begin
      chk(waits == 1, "R3 hit latency", waits, 1);
      chk(wrCnt == wr0 && rdCnt == rd0, "R4 no memory traffic on hit",
          wrCnt - wr0 + rdCnt - rd0, 0);
    end else if (kind == 1) begin
      chk(waits == expLat, "R5 clean miss latency", waits, expLat);
      chk(wrCnt == wr0 && rdCnt == rd0 + 1, "R5 single fetch", wrCnt - wr0, 0);
    end else begin
      chk(waits == expLat, "R6 dirty miss latency", waits, expLat);
      chk(wrCnt == wr0 + 1 && rdCnt == rd0 + 1, "R6 write-back then fetch",
          rdCnt - rd0, 1);
      chk(lastWrAddr == vAddr, "R6 R2 victim address", lastWrAddr, vAddr);
      chk(lastWrData == vLine, "R6 victim data", lastWrData, vLine);
      chk(wrStamp < rdStamp, "R6 write before fetch", wrStamp, rdStamp);
    end
  endtask

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 256; i++) refMem[i] = patWord(i);
    for (int i = 0; i < 64; i++)
      mainMem[i] = {patWord(4*i+3), patWord(4*i+2), patWord(4*i+1), patWord(4*i)};
    for (int i = 0; i < 4; i++) begin mValid[i] = 0; mDirty[i] = 0; mTag[i] = '0; end

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cpuReady == 1'b0, "R1 ready low in reset", cpuReady, 0);
    chk(memValid == 1'b0, "R1 memValid low in reset", memValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(cpuReady == 1'b0 && memValid == 1'b0, "R1 idle after reset", memValid, 0);

    doAccess(0, 32'h000, 0);             // R1 R5 cold read
    doAccess(0, 32'h004, 0);             // R3 hit
    doAccess(0, 32'h00C, 0);             // R2 word select
    doAccess(0, 32'h00D, 0);             // R10 byte bits ignored
    doAccess(1, 32'h008, 32'hAAAA_5555); // R4 write hit
    doAccess(0, 32'h00B, 0);             // R10 R4 read back
    doAccess(0, 32'h040, 0);             // R6 R2 dirty eviction of index 0
    doAccess(0, 32'h008, 0);             // R6 written word came back from memory
    doAccess(1, 32'h014, 32'h1234_5678); // R7 write miss allocate
    doAccess(0, 32'h014, 0);             // R7 merged word
    doAccess(0, 32'h010, 0);             // R7 rest of line from memory
    doAccess(0, 32'h054, 0);             // R7 R6 allocated line is dirty
    doAccess(0, 32'h01C, 0);             // R7 R5 refetch after eviction
    doAccess(0, 32'h020, 0);             // R2 index 2
    doAccess(0, 32'h030, 0);             // R2 index 3

    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 300; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      doAccess(lfsr[31], {22'b0, lfsr[9:0]}, lfsr ^ 32'h5A5A_0F0F);
    end

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R3 all responses seen", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule